// File: doc/BRIEF.md
# Multiplexed LCD Scan Sequencer

This block scans a passive LCD panel with eight common electrodes and thirty-two segment electrodes at 1/8 duty. It reads a 64-word by 4-bit display memory through a synchronous read port. It selects one common per time slot and builds the on/off vector of all segments for that common. For every electrode line it then emits a two-bit drive code, which a separate bias stage turns into analog levels. A slot lasts 64 cycles of the system-rate tick, so a 32768 Hz tick gives 512 slots per second and a 64 Hz frame.

The drive polarity inverts once per frame, so the average voltage across every pixel is zero. Scanning runs only while both the display enable and the system enable are high. While either enable is low, the block blanks all lines to non-select, returns to common 0 and ignores ticks.

At the start of each slot the block fetches all 32 bits of that slot's row from memory, then updates its outputs at one instant. The memory layout puts segment n at two addresses:
- address 2n holds commons 0 to 3, in data bits 0 to 3;
- address 2n+1 holds commons 4 to 7, in data bits 0 to 3.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset, com_idx is 0, seg_on is all zero and every drive code is 00 (non-select, polarity 0).
- R2: Within 50 clock cycles after lcd_on and sys_en are both high, the block shows common 0. For that common, seg_on bit n equals bit 0 of memory word 2n.
- R3: The block advances to the next common after exactly 64 tick pulses. After 63 ticks the displayed common is unchanged.
- R4: For common c in 4..7, seg_on bit n equals bit c-4 of memory word 2n+1. For common c in 0..3, it equals bit c of word 2n.
- R5: The polarity bit inverts each time the scan wraps from common 7 back to common 0, and at no other time.
- R6: com_code holds 2 bits per common, with common k at bits [2k+1:2k]. The upper bit (select) is 1 only for the displayed common. The lower bit is the current polarity.
- R7: seg_code holds 2 bits per segment, with segment n at bits [2n+1:2n]. The upper bit equals seg_on bit n. The lower bit is the current polarity.
- R8: Within 2 cycles after lcd_on goes low, com_idx is 0, seg_on is zero and every code is non-select with the held polarity. Ticks have no effect while lcd_on is low.
- R9: While sys_en is low, the outputs are blanked exactly as in R8 and ticks have no effect.
- R10: A memory write becomes visible at the next slot that reads the written word.
- R11: The polarity is held across a disable and re-enable. After re-enable, scanning restarts at common 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at the system oscillator rate |
| lcd_on | input | 1 | Display enable |
| sys_en | input | 1 | System oscillator and bias enable |
| mem_addr | output | 6 | Display memory read address |
| mem_data | input | 4 | Read data, valid one cycle after mem_addr is registered |
| com_idx | output | 3 | Index of the displayed common |
| seg_on | output | 32 | Segment on/off vector for the displayed common |
| com_code | output | 16 | Drive codes {select, polarity} for each common |
| seg_code | output | 64 | Drive codes {on, polarity} for each segment |

## Verification
The assertions assume that a row fetch finishes before the next slot boundary arrives. This holds because the tick comes at most once per clock and a slot spans 64 ticks, while a fetch takes about 34 cycles. They also assume that memory data returns exactly one cycle after the registered address, as in a synchronous RAM. The bench models that RAM in the same way. It pulses ticks in bursts of 64 or fewer, then idles for 50 cycles before sampling, so every fetch has finished by the time the outputs are checked.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] drv_code_t;

  function automatic drv_code_t mk_code(input logic sel, input logic pol);
    return {sel, pol};
  endfunction
endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int N_COM    = 8,
  parameter int SLOT_DIV = 64,
  localparam int CW = $clog2(N_COM),
  localparam int PW = $clog2(SLOT_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          active,
  output logic          req,
  output logic [CW-1:0] tgt_com,
  output logic          tgt_pol
);
  logic [PW-1:0] presc;
  logic          started;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc   <= '0;
      tgt_com <= '0;
      tgt_pol <= 1'b0;
      started <= 1'b0;
      req     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!active) begin
        presc   <= '0;
        tgt_com <= '0;
        started <= 1'b0;
      end else if (!started) begin
        started <= 1'b1;
        req     <= 1'b1;
        tgt_com <= '0;
      end else if (tick) begin
        if (presc == PW'(SLOT_DIV - 1)) begin
          presc <= '0;
          req   <= 1'b1;
          if (tgt_com == CW'(N_COM - 1)) begin
            tgt_com <= '0;
            tgt_pol <= ~tgt_pol;
          end else begin
            tgt_com <= tgt_com + 1'b1;
          end
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (active && started && !tick) |=> $stable(tgt_com));
  p_pol_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (tgt_pol != $past(tgt_pol)) |-> (tgt_com == '0));
  p_off_home_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (tgt_com == '0) && !req);
endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch #(
  parameter int N_COM = 8,
  parameter int N_SEG = 32,
  parameter int DW    = 4,
  localparam int CW  = $clog2(N_COM),
  localparam int SW  = $clog2(N_SEG),
  localparam int DWB = $clog2(DW),
  localparam int AW  = SW + CW - DWB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             req,
  input  logic [CW-1:0]    tgt_com,
  input  logic             tgt_pol,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_data,
  output logic             done,
  output logic [N_SEG-1:0] row,
  output logic [CW-1:0]    row_com,
  output logic             row_pol
);
  logic          busy, v0, v1;
  logic [SW-1:0] iss_idx, i0, i1;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      busy     <= 1'b0;
      v0       <= 1'b0;
      v1       <= 1'b0;
      done     <= 1'b0;
      iss_idx  <= '0;
      i0       <= '0;
      i1       <= '0;
      mem_addr <= '0;
      if (rst) begin
        row     <= '0;
        row_com <= '0;
        row_pol <= 1'b0;
      end
    end else begin
      done <= 1'b0;
      v0   <= 1'b0;
      v1   <= v0;
      i1   <= i0;
      if (req) begin
        busy    <= 1'b1;
        iss_idx <= '0;
        row_com <= tgt_com;
        row_pol <= tgt_pol;
      end else if (busy) begin
        mem_addr <= {iss_idx, row_com[CW-1:DWB]};
        v0       <= 1'b1;
        i0       <= iss_idx;
        if (iss_idx == SW'(N_SEG - 1)) busy <= 1'b0;
        else iss_idx <= iss_idx + 1'b1;
      end
      if (v1) begin
        row[i1] <= mem_data[row_com[DWB-1:0]];
        if (i1 == SW'(N_SEG - 1)) done <= 1'b1;
      end
    end
  end

  p_req_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    req |-> !busy);
  p_done_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(v1));
endmodule

// File: rtl/lcd_drive_out.sv
module lcd_drive_out
  import lcd_scan_pkg::*;
#(
  parameter int N_COM = 8,
  parameter int N_SEG = 32,
  localparam int CW = $clog2(N_COM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             done,
  input  logic [N_SEG-1:0] row,
  input  logic [CW-1:0]    row_com,
  input  logic             row_pol,
  output logic [CW-1:0]    com_idx,
  output logic [N_SEG-1:0] seg_on,
  output logic [2*N_COM-1:0] com_code,
  output logic [2*N_SEG-1:0] seg_code
);
  logic             pol, shown;
  logic             nxt_pol, nxt_shown;
  logic [CW-1:0]    nxt_com;
  logic [N_SEG-1:0] nxt_seg;
  logic [2*N_COM-1:0] nxt_com_code;
  logic [2*N_SEG-1:0] nxt_seg_code;
  logic [N_COM-1:0] com_sel;

  always_comb begin
    nxt_pol   = pol;
    nxt_shown = shown;
    nxt_com   = com_idx;
    nxt_seg   = seg_on;
    if (!active) begin
      nxt_shown = 1'b0;
      nxt_com   = '0;
      nxt_seg   = '0;
    end else if (done) begin
      nxt_shown = 1'b1;
      nxt_com   = row_com;
      nxt_seg   = row;
      nxt_pol   = row_pol;
    end
  end

  for (genvar k = 0; k < N_COM; k++) begin : g_com
    assign nxt_com_code[2*k +: 2] = mk_code(nxt_shown && (nxt_com == CW'(k)), nxt_pol);
    assign com_sel[k] = com_code[2*k+1];
  end
  for (genvar n = 0; n < N_SEG; n++) begin : g_seg
    assign nxt_seg_code[2*n +: 2] = mk_code(nxt_seg[n], nxt_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol      <= 1'b0;
      shown    <= 1'b0;
      com_idx  <= '0;
      seg_on   <= '0;
      com_code <= '0;
      seg_code <= '0;
    end else begin
      pol      <= nxt_pol;
      shown    <= nxt_shown;
      com_idx  <= nxt_com;
      seg_on   <= nxt_seg;
      com_code <= nxt_com_code;
      seg_code <= nxt_seg_code;
    end
  end

  p_single_select_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_sel));
  p_blank_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (com_sel == '0) && (seg_on == '0) && (com_idx == '0));
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int N_COM    = 8,
  parameter int N_SEG    = 32,
  parameter int DW       = 4,
  parameter int SLOT_DIV = 64,
  localparam int CW = $clog2(N_COM),
  localparam int AW = $clog2(N_SEG) + CW - $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               lcd_on,
  input  logic               sys_en,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_data,
  output logic [CW-1:0]      com_idx,
  output logic [N_SEG-1:0]   seg_on,
  output logic [2*N_COM-1:0] com_code,
  output logic [2*N_SEG-1:0] seg_code
);
  logic             active, req, done, tgt_pol, row_pol;
  logic [CW-1:0]    tgt_com, row_com;
  logic [N_SEG-1:0] row;

  assign active = lcd_on & sys_en;

  lcd_slot_timer #(.N_COM(N_COM), .SLOT_DIV(SLOT_DIV)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .req(req), .tgt_com(tgt_com), .tgt_pol(tgt_pol));

  lcd_row_fetch #(.N_COM(N_COM), .N_SEG(N_SEG), .DW(DW)) u_fetch (
    .clk(clk), .rst(rst), .active(active), .req(req),
    .tgt_com(tgt_com), .tgt_pol(tgt_pol), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .row(row),
    .row_com(row_com), .row_pol(row_pol));

  lcd_drive_out #(.N_COM(N_COM), .N_SEG(N_SEG)) u_drive (
    .clk(clk), .rst(rst), .active(active), .done(done), .row(row),
    .row_com(row_com), .row_pol(row_pol), .com_idx(com_idx),
    .seg_on(seg_on), .com_code(com_code), .seg_code(seg_code));
endmodule

// File: tb/lcd_scan_seq_bench.sv
module lcd_scan_seq_bench;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, lcd_on = 1'b0, sys_en = 1'b0;
  logic [5:0]  mem_addr;
  logic [3:0]  mem_data;
  logic [2:0]  com_idx;
  logic [31:0] seg_on;
  logic [15:0] com_code;
  logic [63:0] seg_code;
  logic [3:0]  mem [64];

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_com = 0;
  logic exp_pol = 1'b0, exp_shown = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) mem_data <= mem[mem_addr];

  lcd_scan_seq u_lcd_scan_seq (
    .clk(clk), .rst(rst), .tick(tick), .lcd_on(lcd_on), .sys_en(sys_en),
    .mem_addr(mem_addr), .mem_data(mem_data), .com_idx(com_idx),
    .seg_on(seg_on), .com_code(com_code), .seg_code(seg_code));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] es;
    logic [15:0] ec;
    logic [63:0] esc;
    for (int n = 0; n < 32; n++) begin
      int a = 2*n + (exp_com >= 4 ? 1 : 0);
      es[n] = exp_shown ? mem[a][exp_com % 4] : 1'b0;
      esc[2*n +: 2] = {es[n], exp_pol};
    end
    for (int k = 0; k < 8; k++) ec[2*k +: 2] = {exp_shown && (k == exp_com), exp_pol};
    cmp({tag, " com_idx"}, 64'(com_idx), exp_shown ? 64'(exp_com) : 64'd0);
    cmp({tag, " seg_on R4"}, 64'(seg_on), 64'(es));
    cmp({tag, " com_code R6"}, 64'(com_code), 64'(ec));
    cmp({tag, " seg_code R7"}, seg_code, esc);
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic advance_slot(input string tag);
    ticks(64);
    clocks(50);
    if (exp_com == 7) begin exp_com = 0; exp_pol = ~exp_pol; end
    else exp_com++;
    check_all(tag);
  endtask

  task automatic t_reset_r1();
    clocks(3);
    rst = 1'b0;
    clocks(2);
    check_all("R1 reset");
  endtask

  task automatic t_enable_r2();
    lcd_on = 1'b1; sys_en = 1'b1;
    clocks(50);
    exp_shown = 1'b1; exp_com = 0;
    check_all("R2 enable");
  endtask

  task automatic t_partial_r3();
    ticks(63);
    clocks(50);
    check_all("R3 63 ticks");
    ticks(1);
    clocks(50);
    exp_com++;
    check_all("R3 64th tick");
  endtask

  task automatic t_upper_r4();
    for (int i = 0; i < 6; i++) advance_slot("R4 scan");
  endtask

  task automatic t_wrap_r5();
    advance_slot("R5 wrap");
    cmp("R5 polarity", 64'(com_code[0]), 64'd1);
    for (int i = 0; i < 8; i++) advance_slot("R5 second frame");
    cmp("R5 polarity back", 64'(com_code[0]), 64'd0);
  endtask

  task automatic t_update_r10();
    for (int n = 0; n < 32; n++) mem[2*n + 1] = ~mem[2*n + 1];
    for (int i = 0; i < 5; i++) advance_slot("R10 update");
  endtask

  task automatic t_lcd_off_r8();
    lcd_on = 1'b0;
    clocks(2);
    exp_shown = 1'b0;
    check_all("R8 off");
    ticks(64);
    clocks(50);
    check_all("R8 ticks ignored");
    lcd_on = 1'b1;
    clocks(50);
    exp_shown = 1'b1; exp_com = 0;
    check_all("R11 restart");
  endtask

  task automatic t_sys_off_r9();
    advance_slot("R9 pre");
    sys_en = 1'b0;
    clocks(2);
    exp_shown = 1'b0;
    check_all("R9 off");
    ticks(64);
    clocks(50);
    check_all("R9 ticks ignored");
    sys_en = 1'b1;
    clocks(50);
    exp_shown = 1'b1; exp_com = 0;
    check_all("R11 restart sys");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 4'((i * 7 + 3) ^ (i >> 2));
    t_reset_r1();
    t_enable_r2();
    t_partial_r3();
    t_upper_r4();
    t_wrap_r5();
    t_update_r10();
    t_lcd_off_r8();
    t_sys_off_r9();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule